// File: doc/BRIEF.md
# Masked Strip Hit Latch with Event Store and Serial Readout

This block is the digital back end of a 64-channel strip front-end chip. It combines the discriminator outputs with a trigger mask into a fast-OR. That fast-OR is merged with the fast-OR arriving from the neighbouring chip, so that a chain of chips forms one layer-wide trigger line.

On a level-1 trigger, the hits that pass a separate data mask are captured into a four-entry event store. Each entry carries the 64 masked hits, a hit-present flag and the 2-bit slot index it was written to. An external controller picks an entry by address with a read command. The entry is then loaded into a 64-bit shift register, which streams toward the left or the right neighbour, one bit per clock. Bits chained in from the previous chip follow directly behind the local bits.

A mode register selects the readout direction and a deaf mode. Deaf mode silences the chip's own trigger activity but still lets the neighbour's fast-OR pass through.

Top module: `strip_event_store`

## Requirements
- R1: `fast_or_out` is combinationally the OR of (`hits` AND trigger mask) ORed with `fast_or_in`, in the same cycle.
- R2: A high `fast_or_in` always drives `fast_or_out` high, in any mode and with any mask.
- R3: After reset both masks are all ones and the mode is 0. A clock edge with `cfg_we` high and `cfg_sel`=0 loads `cfg_data` into the trigger mask, `cfg_sel`=1 loads the data mask, and `cfg_sel`=2 loads `cfg_data[1:0]` into the mode (bit 0 = 1 selects rightward readout, bit 1 = 1 selects deaf mode). The new setting takes effect from the next cycle.
- R4: An accepted `l1_trig` stores the hits ANDed with the data mask, together with flag = OR of those bits and index = write slot, at the write slot. The write slot starts at 0 and advances modulo 4. The occupancy rises by one.
- R5: An `l1_trig` that arrives while all four entries are occupied is dropped: no entry changes and the write slot holds. `overflow` goes high on the next cycle and stays high until reset. This also holds when a read command arrives in the same cycle.
- R6: `rd_cmd` loads the entry at `rd_addr` into the shift register. On the next cycle `rd_flag` and `rd_index` show that entry's flag and index, and the occupancy falls by one if it was nonzero.
- R7: In leftward mode, `sdo_left` shows data bit 63 in the cycle after the load and the next lower bit after each further edge, while `sdo_right` stays 0.
- R8: In rightward mode, `sdo_right` shows data bit 0 first and then ascending bits, while `sdo_left` stays 0.
- R9: The value of `chain_in` at the k-th edge after a load (k counted from 1) appears on the active output 64 cycles later, right behind the last local bit.
- R10: In deaf mode, `l1_trig` is ignored and the local hits do not reach `fast_or_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits | input | 64 | Discriminator outputs |
| fast_or_in | input | 1 | Fast-OR from the previous chip |
| fast_or_out | output | 1 | Layer-wide fast-OR toward the next chip |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 trigger mask, 1 data mask, 2 mode |
| cfg_data | input | 64 | Configuration value |
| l1_trig | input | 1 | Level-1 trigger |
| rd_cmd | input | 1 | Read command |
| rd_addr | input | 2 | Entry to read |
| chain_in | input | 1 | Serial data from the previous chip |
| sdo_left | output | 1 | Serial data toward the left controller |
| sdo_right | output | 1 | Serial data toward the right controller |
| rd_flag | output | 1 | Hit-present flag of the loaded entry |
| rd_index | output | 2 | Write index of the loaded entry |
| overflow | output | 1 | Sticky dropped-trigger flag |

## Verification
The fast-OR is combinational, so it is checked in the same cycle that `hits` or `fast_or_in` changes. Configuration writes and triggers act at the next edge and are observed after that edge. After a read command edge, `rd_flag` and `rd_index` are checked half a cycle later, and local bit j is checked after j further edges. A chained bit is driven half a cycle before it is sampled and checked 64 edges later. All inputs change on the falling edge, and all outputs are sampled just before the next falling edge, so every result is read at a settled point relative to the edge that produced it.

// File: rtl/strip_event_store.sv
module strip_event_store #(
  parameter int NCH   = 64,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = NCH + 1 + AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hits,
  input  logic           fast_or_in,
  output logic           fast_or_out,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [NCH-1:0] cfg_data,
  input  logic           l1_trig,
  input  logic           rd_cmd,
  input  logic [AW-1:0]  rd_addr,
  input  logic           chain_in,
  output logic           sdo_left,
  output logic           sdo_right,
  output logic           rd_flag,
  output logic [AW-1:0]  rd_index,
  output logic           overflow
);

  logic [NCH-1:0] tmask, dmask, sr;
  logic [1:0]     mode;
  logic [EW-1:0]  store [DEPTH];
  logic [AW-1:0]  wptr;
  logic [AW:0]    cnt;

  wire go_right = mode[0];
  wire deaf     = mode[1];
  wire [NCH-1:0] kept = hits & dmask;
  wire full     = (cnt == (AW+1)'(DEPTH));
  wire accept   = l1_trig && !deaf && !full;
  wire drop     = l1_trig && !deaf && full;
  wire release_ = rd_cmd && (cnt != '0);

  assign fast_or_out = fast_or_in | (!deaf && |(hits & tmask));
  assign sdo_left    = !go_right && sr[NCH-1];
  assign sdo_right   = go_right && sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmask <= '1;
      dmask <= '1;
      mode  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    tmask <= cfg_data;
        2'd1:    dmask <= cfg_data;
        2'd2:    mode  <= cfg_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (accept) begin
        store[wptr] <= {|kept, wptr, kept};
        wptr        <= wptr + 1'b1;
      end
      if (drop) overflow <= 1'b1;
      case ({accept, release_})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      rd_flag  <= 1'b0;
      rd_index <= '0;
    end else if (rd_cmd) begin
      sr       <= store[rd_addr][NCH-1:0];
      rd_flag  <= store[rd_addr][EW-1];
      rd_index <= store[rd_addr][NCH +: AW];
    end else if (go_right) begin
      sr <= {chain_in, sr[NCH-1:1]};
    end else begin
      sr <= {sr[NCH-2:0], chain_in};
    end
  end

endmodule

module strip_event_store_chk #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fast_or_in,
  input logic        fast_or_out,
  input logic        l1_trig,
  input logic        rd_cmd,
  input logic        sdo_left,
  input logic        sdo_right,
  input logic        overflow,
  input logic [1:0]  mode,
  input logic [AW:0] cnt
);
  a_r2_chain_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fast_or_in |-> fast_or_out);
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_trig && !mode[1] && cnt == (AW+1)'(DEPTH)) |=> overflow);
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r10_deaf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && l1_trig && !rd_cmd) |=> $stable(cnt));
  a_r7_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_left && sdo_right));
endmodule

bind strip_event_store strip_event_store_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_or_in(fast_or_in), .fast_or_out(fast_or_out),
  .l1_trig(l1_trig), .rd_cmd(rd_cmd), .sdo_left(sdo_left), .sdo_right(sdo_right),
  .overflow(overflow), .mode(mode), .cnt(cnt));

// File: tb/sim_strip_event_store.sv
`timescale 1ns/1ps
module sim_strip_event_store;
  logic clk = 0, rst_n = 0;
  logic [63:0] hits = '0, cfg_data = '0;
  logic fast_or_in = 0, cfg_we = 0, l1_trig = 0, rd_cmd = 0, chain_in = 0;
  logic [1:0] cfg_sel = '0, rd_addr = '0;
  logic fast_or_out, sdo_left, sdo_right, rd_flag, overflow;
  logic [1:0] rd_index;

  int checks = 0, errors = 0;
  logic [63:0] m_tmask, m_dmask, m_data [4];
  logic m_flag [4];
  logic [1:0] m_idx [4], m_mode, m_wptr, m_rptr;
  int m_cnt;
  logic m_ovf;

  strip_event_store u0 (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_or(input logic [63:0] h, input logic fin);
    return fin | (!m_mode[1] && |(h & m_tmask));
  endfunction

  task automatic step; @(posedge clk); @(negedge clk); endtask

  task automatic cfg(input logic [1:0] sel, input logic [63:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_data = d;
    step();
    cfg_we = 0;
    if (sel == 0) m_tmask = d; else if (sel == 1) m_dmask = d; else m_mode = d[1:0];
  endtask

  task automatic trig(input logic [63:0] h);
    hits = h; l1_trig = 1;
    step();
    l1_trig = 0;
    if (!m_mode[1]) begin
      if (m_cnt == 4) m_ovf = 1;
      else begin
        m_data[m_wptr] = h & m_dmask; m_flag[m_wptr] = |(h & m_dmask);
        m_idx[m_wptr] = m_wptr; m_wptr++; m_cnt++;
      end
    end
    chk("R5 overflow", overflow, m_ovf);
  endtask

  task automatic readout(input logic [1:0] a, input logic [3:0] cpat);
    logic [63:0] got;
    rd_cmd = 1; rd_addr = a;
    step();
    rd_cmd = 0;
    if (m_cnt > 0) m_cnt--;
    chk("R6 flag", rd_flag, m_flag[a]);
    chk("R6 index", rd_index, m_idx[a]);
    for (int j = 0; j < 64; j++) begin
      got[j] = m_mode[0] ? sdo_right : sdo_left;
      chk(m_mode[0] ? "R8 idle side" : "R7 idle side", m_mode[0] ? sdo_left : sdo_right, 0);
      chain_in = (j < 4) ? cpat[j] : 1'b0;
      step();
    end
    chk(m_mode[0] ? "R8 right stream" : "R7 left stream", got,
        m_mode[0] ? m_data[a] : {<<{m_data[a]}});
    for (int j = 0; j < 4; j++) begin
      chk("R9 chained", m_mode[0] ? sdo_right : sdo_left, cpat[j]);
      step();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    m_tmask = '1; m_dmask = '1; m_mode = 0; m_wptr = 0; m_rptr = 0; m_cnt = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R3 reset overflow", overflow, 0);
    chk("R3 reset flag", rd_flag, 0);
    hits = 64'h1; #1 chk("R3 reset trigger mask all ones", fast_or_out, 1);
    hits = 0; #1 chk("R1 idle", fast_or_out, 0);
    fast_or_in = 1; #1 chk("R2 pass", fast_or_out, 1);
    fast_or_in = 0;
    cfg(0, 64'h0000_0000_FFFF_0000);
    hits = 64'h8000_0000_0000_0001; #1 chk("R1 masked off", fast_or_out, 0);
    hits = 64'h0000_0000_0010_0000; #1 chk("R1 masked on", fast_or_out, 1);
    cfg(2, 2'b10);
    #1 chk("R10 deaf local", fast_or_out, 0);
    fast_or_in = 1; #1 chk("R2 deaf pass", fast_or_out, 1);
    fast_or_in = 0;
    trig(64'hFFFF);
    cfg(2, 0);
    cfg(1, 64'hF0F0_F0F0_F0F0_F0F0);
    trig(64'h0F0F_0F0F_0F0F_0F0F);
    trig(64'hDEAD_BEEF_1234_5678);
    readout(0, 4'b1011);
    readout(1, 4'b0110);
    m_rptr = 2;
    cfg(1, '1);
    trig(64'h1); trig(64'h8000_0000_0000_0000); trig(64'hAAAA_5555_0000_FFFF);
    trig(64'h1234);
    chk("R5 no overflow yet", overflow, 0);
    hits = 64'hFFFF_FFFF_FFFF_FFFF; l1_trig = 1; rd_cmd = 1; rd_addr = 2'd2;
    step();
    l1_trig = 0; rd_cmd = 0; m_ovf = 1; m_cnt = 3;
    chk("R5 drop with read", overflow, 1);
    chk("R6 index slot2", rd_index, 2'd2);
    cfg(2, 1);
    readout(2'd3, 4'b1101);
    m_rptr = 0;
    readout(2'd0, 4'b0011);
    readout(2'd1, 4'b1000);
    m_rptr = 2;
    chk("R5 sticky", overflow, 1);
    rst_n = 0; step(); rst_n = 1; step();
    m_tmask = '1; m_dmask = '1; m_mode = 0; m_wptr = 0; m_rptr = 0; m_cnt = 0; m_ovf = 0;
    chk("R5 cleared by reset", overflow, 0);
    for (int it = 0; it < 60; it++) begin
      logic [63:0] h;
      h = {$urandom, $urandom} & {$urandom, $urandom};
      case ($urandom % 6)
        0: cfg($urandom % 3, {$urandom, $urandom} | 64'h1);
        1, 2: trig(h);
        3: if (m_cnt > 0) begin readout(m_rptr, 4'($urandom)); m_rptr++; end
        default: begin
          logic fi;
          fi = $urandom % 4 == 0;
          hits = h; fast_or_in = fi;
          #1 chk(fi ? "R2 random" : (m_mode[1] ? "R10 random" : "R1 random"),
                 fast_or_out, exp_or(h, fi));
          step();
          fast_or_in = 0;
        end
      endcase
      if (m_cnt == 4 && ($urandom % 2)) begin readout(m_rptr, 4'b0101); m_rptr++; end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule